// File: doc/BRIEF.md
# Shared Bus Arbiter with Idle Parking

This block decides which of several bus masters may drive the address bus of a shared system bus. Each master raises its own request line. The arbiter answers with a registered grant vector that has at most one bit set. Requests that contend are resolved by fixed priority. A master keeps the grant for its whole address tenure and gives it up when it pulses the address-done input. The arbiter then counts that master's data phase as outstanding until a data-done pulse retires it.

When no master is requesting, a 2-bit parking mode decides where the grant rests:
- on nobody;
- on the master that owned the bus most recently;
- on a master chosen by a 3-bit select input.

A parked master that starts requesting uses its grant straight away and saves an arbitration cycle.

A pipeline-disable input controls how address and data phases overlap. While it is high, no new address grant is issued until every outstanding data phase has retired. While it is low, address tenures may run ahead of data phases up to a parameterised depth. The system is expected to hold this input at 1 out of reset.

Top module: `bus_park_arbiter`

## Requirements
- R1: Out of reset the grant vector is all zero. At every clock it has at most one bit set.
- R2: When no tenure is active, issue is allowed and no parked master is requesting, the lowest-indexed requesting master is granted on the next clock and its tenure starts.
- R3: A granted master keeps the grant, whatever its request line does, until it pulses address-done. On the clock after that pulse the grant vector is zero, and arbitration resumes on the clock after that.
- R4: With parking mode 2'b00 or the reserved code 2'b01, an idle bus with no requests shows an all-zero grant.
- R5: With parking mode 2'b10, an idle bus with no requests parks the grant on the master whose tenure started most recently. Before any tenure has started, the grant is zero.
- R6: With parking mode 2'b11, an idle bus with no requests parks the grant on the master whose index is on the parked-master select input (bit i of the grant is master i).
- R7: If the master holding a parked grant raises its request, it keeps the grant and its tenure starts without a gap cycle, even if a lower-indexed master is also requesting.
- R8: While pipeline-disable is 1 and at least one data phase is outstanding, no new grant is issued and no grant is parked.
- R9: While pipeline-disable is 0, a new grant may be issued while fewer than PIPE_DEPTH data phases are outstanding. With PIPE_DEPTH outstanding, the grant stays zero.
- R10: A data-done pulse while no data phase is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_MASTERS | One request line per master |
| addr_done | input | 1 | Owning master ends its address tenure |
| data_done | input | 1 | Oldest outstanding data phase completes |
| park_mode | input | 2 | Idle parking mode: 00 none, 01 reserved (none), 10 last owner, 11 selected master |
| park_sel | input | $clog2(NUM_MASTERS) | Master index used by parking mode 11 |
| pipe_dis | input | 1 | 1: wait for all data phases before a new grant |
| grant | output | NUM_MASTERS | One-hot (or zero) address-bus grant |

## Verification
The bench builds the block with eight masters and a pipeline depth of two. With that depth, a second address tenure can overlap an outstanding data phase, and the point where a third grant is refused can be reached in a few cycles. The eight masters give the priority pick, the last-owner record and the full three-bit select field a complete index range. Directed sequences drive each parking mode, a parked master winning over a lower index, and the depth limit. A long random run, with mode and pipelining changes mixed in, is compared every clock against a behavioural model.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'b00,
        PARK_RSVD  = 2'b01,
        PARK_LAST  = 2'b10,
        PARK_FIXED = 2'b11
    } park_mode_e;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int NUM_MASTERS = 8
) (
    input  logic [NUM_MASTERS-1:0] req,
    output logic [NUM_MASTERS-1:0] pick_oh,
    output logic                   pick_any
);

    logic [NUM_MASTERS:0] lower_seen;

    assign lower_seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MASTERS; gi++) begin : g_chain
            assign pick_oh[gi]        = req[gi] & ~lower_seen[gi];
            assign lower_seen[gi + 1] = lower_seen[gi] | req[gi];
        end
    endgenerate

    assign pick_any = lower_seen[NUM_MASTERS];

    // R2: the pick is a single requester whenever anyone requests
    always_comb begin
        if (pick_any) begin
            p_pick_valid_r2: assert ($onehot(pick_oh) && ((pick_oh & req) == pick_oh));
        end
    end

endmodule

// File: rtl/arb_park_ctrl.sv
module arb_park_ctrl
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 8,
    localparam int IDX_W = $clog2(NUM_MASTERS)
) (
    input  logic [1:0]             park_mode,
    input  logic [IDX_W-1:0]       park_sel,
    input  logic [IDX_W-1:0]       last_idx,
    input  logic                   last_valid,
    output logic [NUM_MASTERS-1:0] park_oh
);

    logic [NUM_MASTERS-1:0] sel_hit;
    logic [NUM_MASTERS-1:0] last_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MASTERS; gi++) begin : g_dec
            assign sel_hit[gi]  = (park_sel == IDX_W'(gi));
            assign last_hit[gi] = last_valid && (last_idx == IDX_W'(gi));
        end
    endgenerate

    always_comb begin
        unique case (park_mode_e'(park_mode))
            PARK_LAST:  park_oh = last_hit;
            PARK_FIXED: park_oh = sel_hit;
            default:    park_oh = '0;
        endcase
    end

endmodule

// File: rtl/arb_pipe_gate.sv
module arb_pipe_gate #(
    parameter int PIPE_DEPTH = 2,
    localparam int CNT_W = $clog2(PIPE_DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tenure_end,
    input  logic data_done,
    input  logic pipe_dis,
    output logic issue_ok
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             retire;

    always_comb begin
        retire = data_done && (cnt_q != '0);
        cnt_d  = cnt_q;
        unique case ({tenure_end, retire})
            2'b10:   cnt_d = cnt_q + CNT_W'(1);
            2'b01:   cnt_d = cnt_q - CNT_W'(1);
            default: cnt_d = cnt_q;
        endcase
        if (pipe_dis) begin
            issue_ok = (cnt_q == '0);
        end else begin
            issue_ok = (cnt_q < CNT_W'(PIPE_DEPTH));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9: outstanding data phases never exceed the depth
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(PIPE_DEPTH));

    // R10: a retire pulse with nothing outstanding leaves the count at zero
    p_spurious_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) && data_done && !tenure_end |=> cnt_q == '0);

    // R8: with pipelining off, any outstanding phase blocks issue
    p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_dis && (cnt_q != '0) |-> !issue_ok);

endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 8,
    parameter int PIPE_DEPTH  = 2,
    localparam int IDX_W = $clog2(NUM_MASTERS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   addr_done,
    input  logic                   data_done,
    input  logic [1:0]             park_mode,
    input  logic [IDX_W-1:0]       park_sel,
    input  logic                   pipe_dis,
    output logic [NUM_MASTERS-1:0] grant
);

    typedef struct packed {
        logic [NUM_MASTERS-1:0] grant;
        logic                   tenure;
        logic [IDX_W-1:0]       last_idx;
        logic                   last_valid;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_MASTERS-1:0] pick_oh;
    logic                   pick_any;
    logic [NUM_MASTERS-1:0] park_oh;
    logic                   issue_ok;
    logic                   tenure_end;
    logic [IDX_W-1:0]       pick_idx;
    logic [IDX_W-1:0]       held_idx;
    logic                   parked_hit;

    assign tenure_end = st_q.tenure && addr_done;

    arb_prio_pick #(
        .NUM_MASTERS(NUM_MASTERS)
    ) u_pick (
        .req      (req),
        .pick_oh  (pick_oh),
        .pick_any (pick_any)
    );

    arb_park_ctrl #(
        .NUM_MASTERS(NUM_MASTERS)
    ) u_park (
        .park_mode  (park_mode),
        .park_sel   (park_sel),
        .last_idx   (st_q.last_idx),
        .last_valid (st_q.last_valid),
        .park_oh    (park_oh)
    );

    arb_pipe_gate #(
        .PIPE_DEPTH(PIPE_DEPTH)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .tenure_end (tenure_end),
        .data_done  (data_done),
        .pipe_dis   (pipe_dis),
        .issue_ok   (issue_ok)
    );

    always_comb begin
        pick_idx = '0;
        held_idx = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (pick_oh[i]) begin
                pick_idx = IDX_W'(i);
            end
            if (st_q.grant[i]) begin
                held_idx = IDX_W'(i);
            end
        end
        parked_hit = |(st_q.grant & req);

        st_d = st_q;
        if (st_q.tenure) begin
            if (addr_done) begin
                st_d.grant  = '0;
                st_d.tenure = 1'b0;
            end
        end else if (!issue_ok) begin
            st_d.grant = '0;
        end else if (parked_hit) begin
            st_d.tenure     = 1'b1;
            st_d.last_idx   = held_idx;
            st_d.last_valid = 1'b1;
        end else if (pick_any) begin
            st_d.grant      = pick_oh;
            st_d.tenure     = 1'b1;
            st_d.last_idx   = pick_idx;
            st_d.last_valid = 1'b1;
        end else begin
            st_d.grant = park_oh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.grant;

    // R1: never more than one owner
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3: grant is held through the tenure
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tenure && !addr_done |=> $stable(grant));

    // R3: grant drops on the clock after address-done
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tenure && addr_done |=> grant == '0);

    // R4: no parking for modes 00 and 01
    p_no_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tenure && (req == '0) && !park_mode[1] |=> grant == '0);

    // R6: programmed parking follows the select input
    p_fixed_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tenure && issue_ok && (req == '0) && (park_mode == 2'b11)
        |=> grant == (NUM_MASTERS'(1) << $past(park_sel)));

    // R7: a parked requester keeps its grant without a gap
    p_parked_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tenure && issue_ok && |(grant & req) |=> $stable(grant));

    // R8 / R9: no grant while the data pipeline refuses issue
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tenure && !issue_ok |=> grant == '0);

endmodule

// File: tb/bus_park_arbiter_tb.sv
`timescale 1ns/1ps
module bus_park_arbiter_tb;

    localparam int N     = 8;
    localparam int DEPTH = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         addr_done = 1'b0;
    logic         data_done = 1'b0;
    logic [1:0]   park_mode = 2'b00;
    logic [2:0]   park_sel = 3'd0;
    logic         pipe_dis = 1'b1;
    logic [N-1:0] grant;

    int    checks = 0;
    int    errors = 0;
    string phase_tag = "R1";
    bit    done = 1'b0;

    // behavioural reference
    int m_owner = -1;
    bit m_tenure = 0;
    int m_pend = 0;
    int m_last = -1;

    always #2.5 clk = ~clk;

    bus_park_arbiter #(.NUM_MASTERS(N), .PIPE_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr_done(addr_done),
        .data_done(data_done), .park_mode(park_mode), .park_sel(park_sel),
        .pipe_dis(pipe_dis), .grant(grant)
    );

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic logic [N-1:0] as_vec(input int idx);
        return (idx < 0) ? '0 : (N'(1) << idx);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_owner = -1; m_tenure = 0; m_pend = 0; m_last = -1;
        end else begin
            bit ok;
            int nxt_pend;
            ok = pipe_dis ? (m_pend == 0) : (m_pend < DEPTH);
            nxt_pend = m_pend;
            if (m_tenure && addr_done) nxt_pend++;
            if (m_pend > 0 && data_done) nxt_pend--;
            if (m_tenure) begin
                if (addr_done) begin m_tenure = 0; m_owner = -1; end
            end else if (!ok) begin
                m_owner = -1;
            end else if (m_owner >= 0 && req[m_owner]) begin
                m_tenure = 1; m_last = m_owner;
            end else if (req != '0) begin
                m_owner = lowest(req); m_tenure = 1; m_last = m_owner;
            end else if (park_mode == 2'b10) begin
                m_owner = m_last;
            end else if (park_mode == 2'b11) begin
                m_owner = int'(park_sel);
            end else begin
                m_owner = -1;
            end
            m_pend = nxt_pend;
        end
        #1;
        checks++;
        if (grant !== as_vec(m_owner) || !$onehot0(grant)) begin
            errors++;
            $display("FAIL %s (R1 per-cycle) grant=%b expected=%b", phase_tag, grant, as_vec(m_owner));
        end
    end

    task automatic tick(input logic [N-1:0] r, input bit ad, input bit dd);
        @(negedge clk);
        req = r; addr_done = ad; data_done = dd;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [N-1:0] exp);
        checks++;
        if (grant !== exp) begin
            errors++;
            $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset grant zero", 8'h00);
        @(negedge clk); rst_n = 1'b1;

        phase_tag = "R2";
        tick(8'h64, 0, 0); chk("R2 lowest requester 2", 8'h04);
        phase_tag = "R3";
        tick(8'h60, 0, 0); chk("R3 held after request drop", 8'h04);
        tick(8'h60, 1, 0); chk("R3 released after addr_done", 8'h00);
        phase_tag = "R8";
        tick(8'h60, 0, 0); chk("R8 blocked by outstanding data", 8'h00);
        tick(8'h60, 0, 1); chk("R8 blocked on retire clock", 8'h00);
        tick(8'h60, 0, 0); chk("R2 R8 grant after retire", 8'h20);
        tick(8'h00, 1, 0); chk("R3 release", 8'h00);
        tick(8'h00, 0, 1); chk("R8 retire", 8'h00);
        phase_tag = "R4";
        tick(8'h00, 0, 0); chk("R4 mode 00 idle", 8'h00);
        park_mode = 2'b01;
        tick(8'h00, 0, 0); chk("R4 mode 01 idle", 8'h00);
        phase_tag = "R5";
        park_mode = 2'b10;
        tick(8'h00, 0, 0); chk("R5 park on last owner 5", 8'h20);
        phase_tag = "R7";
        tick(8'h21, 0, 0); chk("R7 parked master keeps grant over 0", 8'h20);
        tick(8'h01, 1, 0); chk("R3 release parked tenure", 8'h00);
        tick(8'h00, 0, 1); chk("R8 retire", 8'h00);
        phase_tag = "R6";
        park_mode = 2'b11; park_sel = 3'd6;
        tick(8'h00, 0, 0); chk("R6 park on select 6", 8'h40);
        park_sel = 3'd3;
        tick(8'h00, 0, 0); chk("R6 park on select 3", 8'h08);
        phase_tag = "R10";
        tick(8'h00, 0, 1); chk("R10 spurious retire no effect", 8'h08);
        tick(8'h02, 0, 0); chk("R10 issue still open after spurious retire", 8'h02);
        tick(8'h00, 1, 0); chk("R3 release", 8'h00);
        phase_tag = "R9";
        pipe_dis = 1'b0;
        tick(8'h10, 0, 0); chk("R9 grant with one outstanding", 8'h10);
        tick(8'h80, 1, 0); chk("R3 release second", 8'h00);
        tick(8'h80, 0, 0); chk("R9 blocked at depth", 8'h00);
        tick(8'h80, 0, 1); chk("R9 blocked on retire clock", 8'h00);
        tick(8'h80, 0, 0); chk("R9 grant below depth", 8'h80);
        tick(8'h00, 1, 1);
        tick(8'h00, 0, 1);
        tick(8'h00, 0, 1);

        phase_tag = "R2 random";
        for (int c = 0; c < 4000; c++) begin
            if (c % 97 == 0) begin
                park_mode = 2'($urandom);
                park_sel  = 3'($urandom);
                pipe_dis  = 1'($urandom);
            end
            tick(N'($urandom & $urandom), ($urandom % 3) == 0, ($urandom % 3) == 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule